// File: doc/BRIEF.md
# Radix-26 Modular Multiply-Reduce Unit

This unit multiplies two 130-bit values, each held as five 26-bit limbs with limb 0 as the least significant, modulo 2^130 − 5. It returns a result that is only partially reduced, also as five limbs. The caller supplies the limbs of both operands and, for the second operand, copies of limbs 1 to 4 that have already been multiplied by five. A product term that lands at weight 2^130 or above is therefore folded back in without a separate reduction pass.

The unit samples its operands when `start` is accepted. In the next cycle it forms all 25 limb products into five 64-bit column sums. It then runs a fixed sequence of four carry cycles. The first pass carries limb 0 into 1 and limb 3 into 4. The second carries limb 1 into 2, and it wraps the carry out of limb 4 back into limb 0 after multiplying that carry by five. The third pass carries limb 0 into 1 and limb 2 into 3, and the last pass carries limb 3 into 4. A one-cycle `done` pulse then marks the result as valid.

The unit is meant to sit inside a larger message-authentication accumulator that calls it once per block. That caller handles the final canonical reduction and any key conditioning.

Top module: `mulred26`

## Requirements
- R1: While reset is asserted and after it is released, `done` is 0 and every output limb is 0 until the first operation completes.
- R2: Operands are sampled on the clock edge that accepts `start`. Changing any operand input after that edge has no effect on the result of that operation.
- R3: If `start` is accepted at clock edge k, `done` is 1 for exactly the one cycle that follows edge k+5, and it is 0 in the cycle after that.
- R4: When `done` is 1, the value sum(h[i]·2^(26i)) is congruent to F·G modulo 2^130 − 5. Each output limb i occupies bits [64i+63:64i] of `hLimbs`. Each operand limb i occupies bits [32i+31:32i] of its input. `g5Limbs` lane i−1 carries 5·g[i]. A term f[j]·g[k] with j+k ≥ 5 lands in column j+k−5, scaled by five.
- R5: When `done` is 1, output limbs 0, 2 and 3 are below 2^26, and limbs 1 and 4 are below 2^27.
- R6: A `start` raised while an operation is in progress is ignored. The running operation keeps its timing and result, and no further `done` follows.
- R7: A `start` raised in the cycle where `done` is 1 is accepted. The result on `hLimbs` stays unchanged through the cycle after that accepting edge.
- R8: After `done`, and while no new operation is running, `hLimbs` holds its value.
- R9: Operand limbs as wide as 27 bits (all ones) give a correct result, because the column sums are kept in 64 bits.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Asynchronous reset, active low |
| start | input | 1 | Begin an operation; accepted when idle or in the done cycle |
| fLimbs | input | 160 | Operand F, five 32-bit lanes, limb 0 in bits 31:0 |
| gLimbs | input | 160 | Operand G, five 32-bit lanes |
| g5Limbs | input | 128 | 5·g[1]..5·g[4], four 32-bit lanes, lane 0 = 5·g[1] |
| hLimbs | output | 320 | Result, five 64-bit lanes, limb 0 in bits 63:0 |
| done | output | 1 | One-cycle pulse when the result is valid |

## Verification
The cycle that presents a finished result with `done` is also a cycle in which a new `start` can be accepted. Result presentation and operand capture therefore share one clock edge. The bench raises `start` with fresh operands exactly in the `done` cycle. It then checks that the first result is still on `hLimbs` one cycle later, and that the second operation reports `done` five cycles after its accepting edge with a value congruent to its own product. A second overlap is also covered: a `start` arriving mid-operation must leave the timing and result of the running operation untouched and must not produce a further `done`.

// File: rtl/mulred26_pkg.sv
package mulred26_pkg;
  localparam int NLIMB  = 5;
  localparam int NCARRY = 4;

  typedef struct packed {
    logic              load;
    logic              mul;
    logic [NCARRY-1:0] carry;
  } strobe_t;
endpackage

// File: rtl/mulred26_ctrl.sv
module mulred26_ctrl
  import mulred26_pkg::*;
(
  input  logic    clk,
  input  logic    rstN,
  input  logic    start,
  output strobe_t stb,
  output logic    done
);
  typedef enum logic [2:0] {S_IDLE, S_MUL, S_C1, S_C2, S_C3, S_C4} state_t;
  state_t state;

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      state <= S_IDLE;
      done  <= 1'b0;
    end else begin
      done <= (state == S_C4);
      case (state)
        S_IDLE:  if (start) state <= S_MUL;
        S_MUL:   state <= S_C1;
        S_C1:    state <= S_C2;
        S_C2:    state <= S_C3;
        S_C3:    state <= S_C4;
        S_C4:    state <= S_IDLE;
        default: state <= S_IDLE;
      endcase
    end
  end

  always_comb begin
    stb.load     = (state == S_IDLE) && start;
    stb.mul      = (state == S_MUL);
    stb.carry[0] = (state == S_C1);
    stb.carry[1] = (state == S_C2);
    stb.carry[2] = (state == S_C3);
    stb.carry[3] = (state == S_C4);
  end
endmodule

// File: rtl/mulred26_dp.sv
module mulred26_dp
  import mulred26_pkg::*;
#(
  parameter int LIMB_W = 26,
  parameter int IN_W   = 32,
  parameter int ACC_W  = 64
) (
  input  logic                         clk,
  input  logic                         rstN,
  input  strobe_t                      stb,
  input  logic [NLIMB*IN_W-1:0]        fIn,
  input  logic [NLIMB*IN_W-1:0]        gIn,
  input  logic [(NLIMB-1)*IN_W-1:0]    g5In,
  output logic [NLIMB*ACC_W-1:0]       hOut
);
  localparam logic [ACC_W-1:0] LIMB_MASK = (ACC_W'(1) << LIMB_W) - ACC_W'(1);

  logic [IN_W-1:0]  fWire  [NLIMB];
  logic [IN_W-1:0]  gWire  [NLIMB];
  logic [IN_W-1:0]  g5Wire [NLIMB-1];
  logic [IN_W-1:0]  fQ     [NLIMB];
  logic [IN_W-1:0]  gQ     [NLIMB];
  logic [IN_W-1:0]  g5Q    [NLIMB-1];
  logic [ACC_W-1:0] hQ     [NLIMB];
  logic [ACC_W-1:0] colSum [NLIMB];
  logic [ACC_W-1:0] carried[NLIMB];

  genvar gi;
  generate
    for (gi = 0; gi < NLIMB; gi++) begin : g_unpack
      assign fWire[gi] = fIn[gi*IN_W +: IN_W];
      assign gWire[gi] = gIn[gi*IN_W +: IN_W];
      assign hOut[gi*ACC_W +: ACC_W] = hQ[gi];
    end
    for (gi = 0; gi < NLIMB-1; gi++) begin : g_unpack5
      assign g5Wire[gi] = g5In[gi*IN_W +: IN_W];
    end
  endgenerate

  // column sums: terms that wrap past 2^130 take the 5x copy of g
  always_comb begin
    for (int i = 0; i < NLIMB; i++) begin
      colSum[i] = '0;
      for (int j = 0; j < NLIMB; j++) begin
        int k;
        int k5;
        k  = (i - j + NLIMB) % NLIMB;
        k5 = (k == 0) ? 0 : k - 1;
        if (j > i)
          colSum[i] = colSum[i] + ACC_W'(fQ[j]) * ACC_W'(g5Q[k5]);
        else
          colSum[i] = colSum[i] + ACC_W'(fQ[j]) * ACC_W'(gQ[k]);
      end
    end
  end

  // one carry stage per cycle, two disjoint moves per stage at most
  always_comb begin
    logic [ACC_W-1:0] cA;
    logic [ACC_W-1:0] cB;
    for (int i = 0; i < NLIMB; i++) carried[i] = hQ[i];
    cA = '0;
    cB = '0;
    if (stb.carry[0]) begin
      cA = carried[0] >> LIMB_W;  carried[0] = carried[0] & LIMB_MASK;
      cB = carried[3] >> LIMB_W;  carried[3] = carried[3] & LIMB_MASK;
      carried[1] = carried[1] + cA;
      carried[4] = carried[4] + cB;
    end else if (stb.carry[1]) begin
      cA = carried[1] >> LIMB_W;  carried[1] = carried[1] & LIMB_MASK;
      cB = carried[4] >> LIMB_W;  carried[4] = carried[4] & LIMB_MASK;
      carried[2] = carried[2] + cA;
      carried[0] = carried[0] + (cB << 2) + cB;
    end else if (stb.carry[2]) begin
      cA = carried[0] >> LIMB_W;  carried[0] = carried[0] & LIMB_MASK;
      cB = carried[2] >> LIMB_W;  carried[2] = carried[2] & LIMB_MASK;
      carried[1] = carried[1] + cA;
      carried[3] = carried[3] + cB;
    end else if (stb.carry[3]) begin
      cA = carried[3] >> LIMB_W;  carried[3] = carried[3] & LIMB_MASK;
      carried[4] = carried[4] + cA;
    end
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      for (int i = 0; i < NLIMB; i++) begin
        fQ[i] <= '0;
        gQ[i] <= '0;
        hQ[i] <= '0;
      end
      for (int i = 0; i < NLIMB-1; i++) g5Q[i] <= '0;
    end else begin
      if (stb.load) begin
        for (int i = 0; i < NLIMB; i++) begin
          fQ[i] <= fWire[i];
          gQ[i] <= gWire[i];
        end
        for (int i = 0; i < NLIMB-1; i++) g5Q[i] <= g5Wire[i];
      end
      if (stb.mul) begin
        for (int i = 0; i < NLIMB; i++) hQ[i] <= colSum[i];
      end else if (|stb.carry) begin
        for (int i = 0; i < NLIMB; i++) hQ[i] <= carried[i];
      end
    end
  end
endmodule

// File: rtl/mulred26.sv
module mulred26
  import mulred26_pkg::*;
#(
  parameter int LIMB_W = 26,
  parameter int IN_W   = 32,
  parameter int ACC_W  = 64
) (
  input  logic                      clk,
  input  logic                      rstN,
  input  logic                      start,
  input  logic [NLIMB*IN_W-1:0]     fLimbs,
  input  logic [NLIMB*IN_W-1:0]     gLimbs,
  input  logic [(NLIMB-1)*IN_W-1:0] g5Limbs,
  output logic [NLIMB*ACC_W-1:0]    hLimbs,
  output logic                      done
);
  strobe_t stb;

  mulred26_ctrl ctrl_i (
    .clk   (clk),
    .rstN  (rstN),
    .start (start),
    .stb   (stb),
    .done  (done)
  );

  mulred26_dp #(.LIMB_W(LIMB_W), .IN_W(IN_W), .ACC_W(ACC_W)) dp_i (
    .clk  (clk),
    .rstN (rstN),
    .stb  (stb),
    .fIn  (fLimbs),
    .gIn  (gLimbs),
    .g5In (g5Limbs),
    .hOut (hLimbs)
  );
endmodule

// File: rtl/mulred26_chk.sv
module mulred26_chk
  import mulred26_pkg::*;
#(
  parameter int LIMB_W = 26,
  parameter int ACC_W  = 64
) (
  input logic                   clk,
  input logic                   rstN,
  input logic                   start,
  input logic                   done,
  input logic [NLIMB*ACC_W-1:0] hLimbs
);
  localparam logic [ACC_W-1:0] LIM_N = ACC_W'(1) << LIMB_W;
  localparam logic [ACC_W-1:0] LIM_W = ACC_W'(1) << (LIMB_W + 1);

  // independent cycle model: 0 idle, 1..5 running, 6 done cycle
  logic [2:0] phase;
  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) phase <= 3'd0;
    else if ((phase == 3'd0 || phase == 3'd6) && start) phase <= 3'd1;
    else if (phase == 3'd6) phase <= 3'd0;
    else if (phase != 3'd0) phase <= phase + 3'd1;
  end

  assert_reset_clear_R1: assert property (@(posedge clk)
    !rstN |=> (!done && hLimbs == '0));

  assert_done_pulse_R3: assert property (@(posedge clk) disable iff (!rstN)
    done |=> !done);

  assert_done_timing_R3: assert property (@(posedge clk) disable iff (!rstN)
    done == (phase == 3'd6));

  assert_limb_bounds_R5: assert property (@(posedge clk) disable iff (!rstN)
    done |-> (hLimbs[0*ACC_W +: ACC_W] < LIM_N && hLimbs[1*ACC_W +: ACC_W] < LIM_W &&
              hLimbs[2*ACC_W +: ACC_W] < LIM_N && hLimbs[3*ACC_W +: ACC_W] < LIM_N &&
              hLimbs[4*ACC_W +: ACC_W] < LIM_W));

  assert_hold_after_done_R8: assert property (@(posedge clk) disable iff (!rstN)
    done |=> $stable(hLimbs));

  assert_idle_hold_R8: assert property (@(posedge clk) disable iff (!rstN)
    (phase == 3'd0 && $past(phase) == 3'd0) |-> $stable(hLimbs));
endmodule

bind mulred26 mulred26_chk #(.LIMB_W(LIMB_W), .ACC_W(ACC_W)) chk_i (
  .clk    (clk),
  .rstN   (rstN),
  .start  (start),
  .done   (done),
  .hLimbs (hLimbs)
);

// File: tb/mulred26_tb_top.sv
module mulred26_tb_top;
  localparam int LW = 26;
  localparam int IW = 32;
  localparam int AW = 64;
  localparam int N  = 5;
  localparam logic [399:0] P = (400'd1 << 130) - 400'd5;

  logic clk = 1'b0;
  logic rstN = 1'b0;
  logic start = 1'b0;
  logic [N*IW-1:0] fIn = '0;
  logic [N*IW-1:0] gIn = '0;
  logic [(N-1)*IW-1:0] g5In = '0;
  logic [N*AW-1:0] hLimbs;
  logic done;
  int errors = 0;
  int checks = 0;
  bit finished = 1'b0;

  always #5 clk = ~clk;

  mulred26 dut_i (
    .clk(clk), .rstN(rstN), .start(start), .fLimbs(fIn), .gLimbs(gIn),
    .g5Limbs(g5In), .hLimbs(hLimbs), .done(done)
  );

  task automatic check(input bit ok, input string req, input string what,
                       input logic [399:0] act, input logic [399:0] exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s %s: actual %0h expected %0h", req, what, act, exp);
    end
  endtask

  function automatic logic [399:0] val32(input logic [N*IW-1:0] v);
    logic [399:0] s = '0;
    for (int i = 0; i < N; i++) s = s + (400'(v[i*IW +: IW]) << (LW*i));
    return s;
  endfunction

  function automatic logic [399:0] val64(input logic [N*AW-1:0] v);
    logic [399:0] s = '0;
    for (int i = 0; i < N; i++) s = s + (400'(v[i*AW +: AW]) << (LW*i));
    return s;
  endfunction

  function automatic logic [(N-1)*IW-1:0] g5Of(input logic [N*IW-1:0] g);
    logic [(N-1)*IW-1:0] r;
    for (int k = 1; k < N; k++) r[(k-1)*IW +: IW] = g[k*IW +: IW] * 32'd5;
    return r;
  endfunction

  function automatic bit boundsOk(input logic [N*AW-1:0] h);
    bit ok = 1'b1;
    for (int i = 0; i < N; i++)
      if (h[i*AW +: AW] >= ((i == 1 || i == 4) ? (64'd1 << 27) : (64'd1 << 26))) ok = 1'b0;
    return ok;
  endfunction

  // drive and accept at one edge, then scramble operands (R2)
  task automatic launch(input logic [N*IW-1:0] f, input logic [N*IW-1:0] g);
    @(negedge clk);
    fIn = f; gIn = g; g5In = g5Of(g); start = 1'b1;
    @(posedge clk);
    @(negedge clk);
    start = 1'b0; fIn = ~f; gIn = ~g; g5In = '1;
  endtask

  task automatic waitDone(output int lat);
    lat = 0;
    while (!done && lat < 20) begin
      @(negedge clk);
      lat++;
    end
  endtask

  task automatic checkValue(input logic [N*IW-1:0] f, input logic [N*IW-1:0] g,
                            input string req);
    logic [399:0] expV, gotV;
    expV = (val32(f) * val32(g)) % P;
    gotV = val64(hLimbs) % P;
    check(gotV == expV, req, "congruent result", gotV, expV);
    check(boundsOk(hLimbs), "R5", "limb bounds", val64(hLimbs), '0);
  endtask

  task automatic testReset;
    check(done == 1'b0, "R1", "done after reset", 400'(done), '0);
    check(hLimbs == '0, "R1", "limbs after reset", 400'(hLimbs), '0);
  endtask

  task automatic testIdentity;
    logic [N*IW-1:0] f, g;
    logic [N*AW-1:0] expH;
    int lat;
    f = '0; f[0 +: IW] = 32'd1;
    g = {32'h0123456, 32'h2abcdef, 32'h0001234, 32'h3ffffff, 32'h0000777};
    expH = '0;
    for (int i = 0; i < N; i++) expH[i*AW +: AW] = 64'(g[i*IW +: IW]);
    launch(f, g);
    waitDone(lat);
    check(lat == 5, "R3", "done latency", 400'(lat), 400'd5);
    check(hLimbs == expH, "R4", "identity exact", 400'(hLimbs), 400'(expH));
    check(hLimbs == expH, "R2", "operands scrambled after start", 400'(hLimbs), 400'(expH));
    @(negedge clk);
    check(done == 1'b0, "R3", "done one cycle", 400'(done), '0);
  endtask

  task automatic testWrap;
    logic [N*IW-1:0] f, g;
    logic [N*AW-1:0] expH;
    int lat;
    f = '0; g = '0; f[1*IW +: IW] = 32'd1; g[4*IW +: IW] = 32'd1000;
    expH = '0; expH[0 +: AW] = 64'd5000;
    launch(f, g);
    waitDone(lat);
    check(hLimbs == expH, "R4", "wrap limb1*limb4 to limb0", 400'(hLimbs), 400'(expH));
    f = '0; g = '0; f[4*IW +: IW] = 32'd3; g[3*IW +: IW] = 32'd7;
    expH = '0; expH[2*AW +: AW] = 64'd105;
    launch(f, g);
    waitDone(lat);
    check(hLimbs == expH, "R4", "wrap limb4*limb3 to limb2", 400'(hLimbs), 400'(expH));
  endtask

  task automatic testRandom;
    for (int t = 0; t < 6; t++) begin
      logic [N*IW-1:0] f, g;
      int lat;
      for (int i = 0; i < N; i++) begin
        f[i*IW +: IW] = $urandom & 32'h3ffffff;
        g[i*IW +: IW] = $urandom & 32'h3ffffff;
      end
      launch(f, g);
      waitDone(lat);
      checkValue(f, g, "R4");
    end
  endtask

  task automatic testMax;
    logic [N*IW-1:0] f, g;
    int lat;
    for (int i = 0; i < N; i++) begin
      f[i*IW +: IW] = 32'h7ffffff;
      g[i*IW +: IW] = 32'h7ffffff;
    end
    launch(f, g);
    waitDone(lat);
    checkValue(f, g, "R9");
  endtask

  task automatic testBusyStart;
    logic [N*IW-1:0] f, g;
    int lat, extra;
    for (int i = 0; i < N; i++) begin
      f[i*IW +: IW] = 32'h1000 + 32'(i);
      g[i*IW +: IW] = 32'h2345 * 32'(i + 1);
    end
    launch(f, g);
    @(negedge clk);
    start = 1'b1; fIn = '1; gIn = '1; g5In = '1;
    @(negedge clk);
    start = 1'b0;
    waitDone(lat);
    check(lat + 2 == 5, "R6", "latency with busy start", 400'(lat + 2), 400'd5);
    checkValue(f, g, "R6");
    extra = 0;
    for (int c = 0; c < 10; c++) begin
      @(negedge clk);
      if (done) extra++;
    end
    check(extra == 0, "R6", "no second done", 400'(extra), '0);
  endtask

  task automatic testBackToBack;
    logic [N*IW-1:0] fa, ga, fb, gb;
    logic [N*AW-1:0] hold;
    int lat;
    for (int i = 0; i < N; i++) begin
      fa[i*IW +: IW] = 32'h3000000 - 32'(i * 77);
      ga[i*IW +: IW] = 32'h0abcdef + 32'(i);
      fb[i*IW +: IW] = 32'h0000400 + 32'(i * 9);
      gb[i*IW +: IW] = 32'h1fedcba - 32'(i);
    end
    launch(fa, ga);
    waitDone(lat);
    checkValue(fa, ga, "R7");
    hold = hLimbs;
    fIn = fb; gIn = gb; g5In = g5Of(gb); start = 1'b1;
    @(posedge clk);
    @(negedge clk);
    start = 1'b0; fIn = '0; gIn = '0; g5In = '0;
    check(hLimbs == hold, "R7", "result kept after accepting edge", 400'(hLimbs), 400'(hold));
    waitDone(lat);
    check(lat == 5, "R7", "second op latency", 400'(lat), 400'd5);
    checkValue(fb, gb, "R7");
  endtask

  task automatic testHold;
    logic [N*AW-1:0] hold;
    hold = hLimbs;
    repeat (6) @(negedge clk);
    check(hLimbs == hold, "R8", "idle hold", 400'(hLimbs), 400'(hold));
    check(done == 1'b0, "R8", "done idle", 400'(done), '0);
  endtask

  initial begin
    repeat (3) @(negedge clk);
    testReset();
    rstN = 1'b1;
    @(negedge clk);
    testReset();
    testIdentity();
    testWrap();
    testRandom();
    testMax();
    testBusyStart();
    testBackToBack();
    testHold();
    finished = 1'b1;
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

  initial begin
    repeat (200000) @(posedge clk);
    if (!finished) begin
      checks++;
      errors++;
      $display("FAIL watchdog: actual hung expected finish");
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
    end
  end
endmodule